// File: doc/BRIEF.md
# Register-Amount Shifter with Carry-Out

This block shifts a data word left or right by an amount read from a register operand. It supports logical left, logical right, arithmetic right and rotate right. Besides the shifted word it produces the carry flag that the operation leaves behind. An execute stage uses it when an instruction takes its shift count from a register rather than from an immediate.

The amount is the whole low byte of the operand, not only the bits needed to index a bit position. Amounts equal to or larger than the word width therefore follow defined rules for both result and carry. An amount of zero passes the word through and returns the incoming carry unchanged. The block is purely combinational. Each output is a function of the current inputs only.

Top module: `reg_shifter`

## Requirements
- R1: Only the low 8 bits of `amt_src` set the effective amount; changing bits 31:8 has no effect on `data_out` or `carry_out`.
- R2: With an effective amount of 0, for any `op_sel`, `data_out` equals `data_in` and `carry_out` equals `carry_in`.
- R3: With `op_sel`=00 (logical left) and an amount from 1 to 31, `data_out` is `data_in` shifted left with zero fill, and `carry_out` is `data_in` bit (32 − amount).
- R4: Logical left with amount 32 gives `data_out`=0 and `carry_out`=`data_in[0]`; with any amount above 32 it gives 0 and carry 0.
- R5: With `op_sel`=01 (logical right) and an amount from 1 to 31, `data_out` is shifted right with zero fill, and `carry_out` is `data_in` bit (amount − 1).
- R6: Logical right with amount 32 gives 0 and carry `data_in[31]`; with any amount above 32 it gives 0 and carry 0.
- R7: With `op_sel`=10 (arithmetic right), an amount from 1 to 31 shifts in copies of bit 31, with carry `data_in` bit (amount − 1). Any amount of 32 or more gives bit 31 copied into all bits, with carry `data_in[31]`.
- R8: With `op_sel`=11 (rotate right), an amount whose low 5 bits m are nonzero rotates right by m, and `carry_out` is `data_in` bit (m − 1). This equals bit 31 of the result.
- R9: Rotate right with a nonzero amount whose low 5 bits are zero (32, 64, ... 224) returns `data_in` unchanged, with carry `data_in[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 32 | Word to shift |
| amt_src | input | 32 | Register operand; its low byte is the amount |
| op_sel | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_in | input | 1 | Current carry flag |
| data_out | output | 32 | Shifted word |
| carry_out | output | 1 | New carry flag |

## Verification
No register lies between any input and either output, so `data_out` and `carry_out` are due in the same cycle as the stimulus, zero clock edges later. The bench applies each stimulus on the falling clock edge and samples 1 ns later. The outputs have settled by then, and the next rising edge is still well away. Each scenario task compares the outputs against a separate behavioural model written from the requirements. The sweep covers every amount from 0 to 255 for all four operations.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_LSR = 2'b01,
    OP_ASR = 2'b10,
    OP_ROR = 2'b11
  } shf_op_e;
endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode #(
  parameter int W     = 32,
  parameter int SRC_W = 32,
  parameter int AMT_W = 8,
  localparam int SH_W = $clog2(W)
) (
  input  logic [SRC_W-1:0] amt_src,
  output logic [SH_W-1:0]  amt_lo,
  output logic             amt_zero,
  output logic             amt_eq_w,
  output logic             amt_gt_w,
  output logic             rot_wrap
);
  logic [AMT_W-1:0] amt;
  logic             unused_hi;

  assign amt       = amt_src[AMT_W-1:0];
  assign unused_hi = ^amt_src[SRC_W-1:AMT_W];
  assign amt_lo    = amt[SH_W-1:0];
  assign amt_zero  = (amt == '0);
  assign amt_eq_w  = (amt == AMT_W'(W));
  assign amt_gt_w  = (amt >  AMT_W'(W));
  assign rot_wrap  = !amt_zero && (amt_lo == '0);
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W:0]      vec_in,
  input  logic [SH_W-1:0] amt,
  input  logic            rot,
  input  logic            fill,
  output logic [W:0]      vec_out
);
  logic [W-1:0] dat;

  always_comb begin
    vec_out = vec_in;
    for (int k = 0; k < SH_W; k++) begin
      if (amt[k]) begin
        if (rot) begin
          dat     = vec_out[W:1];
          dat     = (dat >> (1 << k)) | (dat << (W - (1 << k)));
          vec_out = {dat, 1'b0};
        end else begin
          vec_out = (vec_out >> (1 << k)) |
                    (fill ? ~({(W+1){1'b1}} >> (1 << k)) : '0);
        end
      end
    end
    dat = vec_out[W:1];
  end
endmodule

// File: rtl/shf_outsel.sv
module shf_outsel
  import shf_pkg::*;
#(
  parameter int W = 32
) (
  input  shf_op_e      op,
  input  logic [W-1:0] din,
  input  logic         cin,
  input  logic         amt_zero,
  input  logic         amt_eq_w,
  input  logic         amt_gt_w,
  input  logic         rot_wrap,
  input  logic [W-1:0] sh_data,
  input  logic         sh_guard,
  output logic [W-1:0] dout,
  output logic         cout
);
  always_comb begin
    dout = sh_data;
    cout = sh_guard;
    if (amt_zero) begin
      dout = din;
      cout = cin;
    end else begin
      unique case (op)
        OP_LSL: if (amt_gt_w) begin dout = '0; cout = 1'b0; end
                else if (amt_eq_w) begin dout = '0; cout = din[0]; end
        OP_LSR: if (amt_gt_w) begin dout = '0; cout = 1'b0; end
                else if (amt_eq_w) begin dout = '0; cout = din[W-1]; end
        OP_ASR: if (amt_gt_w || amt_eq_w) begin
                  dout = {W{din[W-1]}};
                  cout = din[W-1];
                end
        OP_ROR: if (rot_wrap) begin dout = din; cout = din[W-1]; end
                else cout = sh_data[W-1];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/reg_shifter.sv
module reg_shifter
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int SRC_W = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     data_in,
  input  logic [SRC_W-1:0] amt_src,
  input  logic [1:0]       op_sel,
  input  logic             carry_in,
  output logic [W-1:0]     data_out,
  output logic             carry_out
);
  localparam int SH_W = $clog2(W);

  shf_op_e         op;
  logic [SH_W-1:0] amt_lo;
  logic            amt_zero, amt_eq_w, amt_gt_w, rot_wrap;
  logic [W-1:0]    din_rev, bar_rev, pre_data, post_data;
  logic [W:0]      bar_out;
  logic            is_left;

  assign op      = shf_op_e'(op_sel);
  assign is_left = (op == OP_LSL);

  shf_amt_decode #(.W(W), .SRC_W(SRC_W), .AMT_W(AMT_W)) u_dec (
    .amt_src (amt_src),
    .amt_lo  (amt_lo),
    .amt_zero(amt_zero),
    .amt_eq_w(amt_eq_w),
    .amt_gt_w(amt_gt_w),
    .rot_wrap(rot_wrap)
  );

  // Left shifts reuse the right-shifting core on bit-reversed words.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign din_rev[i] = data_in[W-1-i];
    assign bar_rev[i] = bar_out[W-i];
  end

  assign pre_data  = is_left ? din_rev : data_in;
  assign post_data = is_left ? bar_rev : bar_out[W:1];

  shf_barrel #(.W(W)) u_bar (
    .vec_in ({pre_data, 1'b0}),
    .amt    (amt_lo),
    .rot    (op == OP_ROR),
    .fill   ((op == OP_ASR) && data_in[W-1]),
    .vec_out(bar_out)
  );

  shf_outsel #(.W(W)) u_sel (
    .op      (op),
    .din     (data_in),
    .cin     (carry_in),
    .amt_zero(amt_zero),
    .amt_eq_w(amt_eq_w),
    .amt_gt_w(amt_gt_w),
    .rot_wrap(rot_wrap),
    .sh_data (post_data),
    .sh_guard(bar_out[0]),
    .dout    (data_out),
    .cout    (carry_out)
  );
endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
  parameter int W     = 32,
  parameter int SRC_W = 32,
  parameter int AMT_W = 8
) (
  input logic [W-1:0]     data_in,
  input logic [SRC_W-1:0] amt_src,
  input logic [1:0]       op_sel,
  input logic             carry_in,
  input logic [W-1:0]     data_out,
  input logic             carry_out
);
  localparam int SH_W = $clog2(W);
  logic [AMT_W-1:0] a;
  logic             unused_chk_hi;
  assign a             = amt_src[AMT_W-1:0];
  assign unused_chk_hi = ^amt_src[SRC_W-1:AMT_W];

  always_comb begin
    if (!$isunknown({data_in, a, op_sel, carry_in})) begin
      // R2
      zero_amt_pass_chk: assert (a != '0 || (data_out == data_in && carry_out == carry_in));
      // R4
      lsl_beyond_chk: assert (!(op_sel == 2'b00 && a > AMT_W'(W)) || (data_out == '0 && !carry_out));
      // R6
      lsr_beyond_chk: assert (!(op_sel == 2'b01 && a > AMT_W'(W)) || (data_out == '0 && !carry_out));
      // R7
      asr_sign_fill_chk: assert (!(op_sel == 2'b10 && a >= AMT_W'(W)) ||
                                 (data_out == {W{data_in[W-1]}} && carry_out == data_in[W-1]));
      // R8
      ror_carry_top_chk: assert (!(op_sel == 2'b11 && a[SH_W-1:0] != '0) || carry_out == data_out[W-1]);
      // R9
      ror_wrap_chk: assert (!(op_sel == 2'b11 && a != '0 && a[SH_W-1:0] == '0) ||
                            (data_out == data_in && carry_out == data_in[W-1]));
    end
  end
endmodule

bind reg_shifter shf_checker #(.W(W), .SRC_W(SRC_W), .AMT_W(AMT_W)) u_chk (
  .data_in  (data_in),
  .amt_src  (amt_src),
  .op_sel   (op_sel),
  .carry_in (carry_in),
  .data_out (data_out),
  .carry_out(carry_out)
);

// File: tb/reg_shifter_bench.sv
module reg_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data_in = '0;
  logic [31:0] amt_src = '0;
  logic [1:0]  op_sel = '0;
  logic        carry_in = 1'b0;
  logic [31:0] data_out;
  logic        carry_out;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  reg_shifter u_reg_shifter (
    .data_in(data_in), .amt_src(amt_src), .op_sel(op_sel),
    .carry_in(carry_in), .data_out(data_out), .carry_out(carry_out)
  );

  task automatic model(input logic [31:0] d, input logic [31:0] s, input logic [1:0] op,
                       input logic c, output logic [31:0] r, output logic co);
    int a;
    int m;
    a = int'(s[7:0]);
    m = a % 32;
    r = d; co = c;
    if (a != 0) begin
      case (op)
        2'b00: if (a > 32) begin r = 0; co = 0; end
               else if (a == 32) begin r = 0; co = d[0]; end
               else begin r = d << a; co = d[32-a]; end
        2'b01: if (a > 32) begin r = 0; co = 0; end
               else if (a == 32) begin r = 0; co = d[31]; end
               else begin r = d >> a; co = d[a-1]; end
        2'b10: if (a >= 32) begin r = {32{d[31]}}; co = d[31]; end
               else begin r = 32'($signed(d) >>> a); co = d[a-1]; end
        default: if (m == 0) begin r = d; co = d[31]; end
                 else begin r = (d >> m) | (d << (32 - m)); co = d[m-1]; end
      endcase
    end
  endtask

  task automatic apply_check(input string req, input logic [31:0] d, input logic [31:0] s,
                             input logic [1:0] op, input logic c);
    logic [31:0] er;
    logic        ec;
    @(negedge clk);
    data_in = d; amt_src = s; op_sel = op; carry_in = c;
    model(d, s, op, c, er, ec);
    #1;
    total++;
    if (data_out !== er || carry_out !== ec) begin
      bad++;
      $display("FAIL %s op=%0d amt=%h din=%h: got %h/%0b expected %h/%0b",
               req, op, s, d, data_out, carry_out, er, ec);
    end
  endtask

  task automatic t_reset;
    #1;
    total++;
    if (data_out !== 32'h0 || carry_out !== 1'b0) begin
      bad++;
      $display("FAIL R2 reset state: got %h/%0b expected 0/0", data_out, carry_out);
    end
  endtask

  task automatic t_zero_amount;
    for (int op = 0; op < 4; op++) begin
      apply_check("R2", 32'hDEAD_BEEF, 32'h0, 2'(op), 1'b1);
      apply_check("R2", 32'h1234_5678, 32'hFF00, 2'(op), 1'b0);
    end
  endtask

  task automatic t_lsl;
    apply_check("R3", 32'h8000_0001, 32'd1, 2'b00, 1'b0);
    apply_check("R3", 32'h0000_0001, 32'd31, 2'b00, 1'b0);
    apply_check("R4", 32'h0000_0001, 32'd32, 2'b00, 1'b0);
    apply_check("R4", 32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1);
  endtask

  task automatic t_lsr;
    apply_check("R5", 32'h0000_0001, 32'd1, 2'b01, 1'b0);
    apply_check("R5", 32'h8000_0000, 32'd31, 2'b01, 1'b0);
    apply_check("R6", 32'h8000_0000, 32'd32, 2'b01, 1'b0);
    apply_check("R6", 32'hFFFF_FFFF, 32'd200, 2'b01, 1'b1);
  endtask

  task automatic t_asr;
    apply_check("R7", 32'h8000_0010, 32'd5, 2'b10, 1'b0);
    apply_check("R7", 32'h8000_0000, 32'd32, 2'b10, 1'b0);
    apply_check("R7", 32'h7FFF_FFFF, 32'd255, 2'b10, 1'b0);
  endtask

  task automatic t_ror;
    apply_check("R8", 32'h0000_0001, 32'd1, 2'b11, 1'b0);
    apply_check("R8", 32'h1234_5678, 32'd36, 2'b11, 1'b0);
    apply_check("R9", 32'h8765_4321, 32'd32, 2'b11, 1'b0);
    apply_check("R9", 32'h0000_0001, 32'd224, 2'b11, 1'b1);
  endtask

  task automatic t_upper_ignored;
    // R1: same low byte with different upper bits must give the same outcome
    apply_check("R1", 32'hA5A5_0F0F, 32'hFFFF_FF04, 2'b00, 1'b0);
    apply_check("R1", 32'hA5A5_0F0F, 32'h1234_5600, 2'b01, 1'b1);
    apply_check("R1", 32'h8000_0F0F, 32'h0000_0120, 2'b10, 1'b0);
    apply_check("R1", 32'hA5A5_0F0F, 32'hABCD_EF21, 2'b11, 1'b0);
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 256; a++)
        apply_check("R3-sweep", $urandom(), {$urandom() & 32'hFFFF_FF00} | 32'(a),
                    2'(op), 1'($urandom()));
  endtask

  initial begin
    #50000000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_zero_amount();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_upper_ignored();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule